// File: doc/BRIEF.md
# Packed-Lane Saturating Integer ALU

This execute-stage unit treats each of its two 32-bit source operands as a vector of small integers. With the lane select, the operands hold either two 16-bit lanes or four 8-bit lanes. A 4-bit function code picks one operation, and the unit applies it to every lane on its own. The lanes are fully isolated from each other. No carry, borrow or shifted bit ever crosses a lane boundary. Each lane is also compared, clamped or sign-filled using only its own bits.

The available operations are:
- wrapping add and subtract
- saturating add and subtract, in signed and unsigned forms
- lane-wise minimum and maximum, signed and unsigned
- left-logical, right-logical and right-arithmetic shifts by an immediate amount

The result passes through one register stage. A request presented with `in_valid` high appears on `rd_data` one clock later, together with `out_valid`. Decode, the register file and any multiply or reformatting operations sit outside the block.

Top module: `simd_sat_alu`

## Requirements
- R1: After reset, `rd_data` is 0 and `out_valid` is 0. A request accepted with `in_valid` high at a rising edge sets `out_valid` high and shows its result on `rd_data` after that same edge. `out_valid` is low after any edge at which `in_valid` was low.
- R2: `lane_sel` = 0 selects two 16-bit lanes, with lane k occupying bits [16k+15:16k]. `lane_sel` = 1 selects four 8-bit lanes, with lane k occupying bits [8k+7:8k]. Every operation works on each lane independently.
- R3: Code 0 is a wrapping add and code 1 is a wrapping subtract. Each lane is computed modulo 2^lane-width, and no carry or borrow enters the neighbouring lane.
- R4: Code 2 is a signed saturating add and code 4 is a signed saturating subtract. An overflowing lane clamps to its most positive value (0x7F or 0x7FFF) or to its most negative value (0x80 or 0x8000).
- R5: Code 3 is an unsigned saturating add, which clamps a lane to all ones on carry out. Code 5 is an unsigned saturating subtract, which clamps a lane to zero on borrow.
- R6: Code 6 gives the per-lane signed minimum and code 7 gives the per-lane unsigned minimum.
- R7: Code 8 gives the per-lane signed maximum and code 9 gives the per-lane unsigned maximum.
- R8: Code 10 shifts each lane left and fills with zeros. The shift amount is `shamt` modulo the lane width, so 8-bit lanes use only `shamt[2:0]`.
- R9: Code 11 is a logical right shift that fills with zeros. Code 12 is an arithmetic right shift that fills with the lane's own sign bit. Both use the amount modulo the lane width.
- R10: Codes 13, 14 and 15 produce an all-zero result.
- R11: While `in_valid` is low, `rd_data` keeps its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Function code (see R3 to R10) |
| lane_sel | input | 1 | 0: 16-bit lanes, 1: 8-bit lanes |
| src_a | input | 32 | First packed operand |
| src_b | input | 32 | Second packed operand |
| shamt | input | 4 | Immediate shift amount |
| out_valid | output | 1 | Result valid on `rd_data` |
| rd_data | output | 32 | Registered packed result |

## Verification
The assertions inside each lane check the ordering relations continuously, for every lane and every cycle:
- an unsigned saturating add never falls below either operand
- an unsigned saturating subtract never exceeds the minuend
- a minimum or maximum is always one of the two operands and is bounded correctly
- a signed saturating add of two non-negative lanes never turns negative
- a logical right shift never grows a lane

At the top level, the assertions also check the one-cycle valid timing and that `rd_data` holds while idle.

Exact clamp values, wrap results without cross-lane carry, shift modulo behaviour and the zero result of unused codes can only be shown by the bench's scenarios. These scenarios compare each result with a lane-by-lane reference at the boundary operands 0x7F/0x80, 0x7FFF/0x8000 and 0x00/0xFF.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_ADDS = 4'd2,
      OP_ADDU = 4'd3,
      OP_SUBS = 4'd4,
      OP_SUBU = 4'd5,
      OP_MINS = 4'd6,
      OP_MINU = 4'd7,
      OP_MAXS = 4'd8,
      OP_MAXU = 4'd9,
      OP_SLL  = 4'd10,
      OP_SRL  = 4'd11,
      OP_SRA  = 4'd12
   } simd_op_e;
endpackage

// File: rtl/simd_lane_unit.sv
// One lane of width W: every operation of the unit, with no outside coupling.
module simd_lane_unit
   import simd_alu_pkg::*;
#(
   parameter int W   = 8,
   localparam int SHW = $clog2(W)
) (
   input  simd_op_e         op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [SHW-1:0]   sh,
   output logic [W-1:0]     y
);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] UMAX = {W{1'b1}};

   logic [W:0] sum_x;
   logic [W:0] dif_x;
   logic       s_add_ovf, s_sub_ovf, s_lt, u_lt;

   always_comb begin
      sum_x     = {1'b0, a} + {1'b0, b};
      dif_x     = {1'b0, a} - {1'b0, b};
      s_add_ovf = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
      s_sub_ovf = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
      s_lt      = $signed(a) < $signed(b);
      u_lt      = a < b;
      y         = '0;
      unique case (op)
         OP_ADD:  y = sum_x[W-1:0];
         OP_SUB:  y = dif_x[W-1:0];
         OP_ADDS: y = s_add_ovf ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
         OP_SUBS: y = s_sub_ovf ? (a[W-1] ? SMIN : SMAX) : dif_x[W-1:0];
         OP_ADDU: y = sum_x[W] ? UMAX : sum_x[W-1:0];
         OP_SUBU: y = dif_x[W] ? '0 : dif_x[W-1:0];
         OP_MINS: y = s_lt ? a : b;
         OP_MINU: y = u_lt ? a : b;
         OP_MAXS: y = s_lt ? b : a;
         OP_MAXU: y = u_lt ? b : a;
         OP_SLL:  y = a << sh;
         OP_SRL:  y = a >> sh;
         OP_SRA:  y = $signed(a) >>> sh;
         default: y = '0;
      endcase

      assert_addu_floor_R5: assert (op != OP_ADDU || (y >= a && y >= b));
      assert_subu_ceiling_R5: assert (op != OP_SUBU || y <= a);
      assert_adds_nonneg_R4: assert (op != OP_ADDS || a[W-1] || b[W-1] || !y[W-1]);
      assert_minu_bound_R6: assert (op != OP_MINU || ((y == a || y == b) && y <= a && y <= b));
      assert_mins_bound_R6: assert (op != OP_MINS ||
                                    ($signed(y) <= $signed(a) && $signed(y) <= $signed(b)));
      assert_maxu_bound_R7: assert (op != OP_MAXU || ((y == a || y == b) && y >= a && y >= b));
      assert_maxs_bound_R7: assert (op != OP_MAXS ||
                                    ($signed(y) >= $signed(a) && $signed(y) >= $signed(b)));
      assert_srl_shrink_R9: assert (op != OP_SRL || y <= a);
   end
endmodule

// File: rtl/simd_lane_array.sv
// Replicates the lane unit across an XLEN-bit word for one lane width.
module simd_lane_array
   import simd_alu_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int W    = 8,
   localparam int NL  = XLEN / W,
   localparam int SHW = $clog2(W)
) (
   input  simd_op_e          op,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   input  logic [SHW-1:0]    shamt,
   output logic [XLEN-1:0]   y
);
   if (XLEN % W != 0 || W < 2) begin : g_bad_width
      $error("lane width must divide the word and be at least 2");
   end

   for (genvar k = 0; k < NL; k++) begin : g_lane
      simd_lane_unit #(.W(W)) u_lane (
         .op (op),
         .a  (a[k*W +: W]),
         .b  (b[k*W +: W]),
         .sh (shamt),
         .y  (y[k*W +: W])
      );
   end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
   import simd_alu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int WIDE   = 16,
   parameter int NARROW = 8,
   localparam int SHW_W = $clog2(WIDE),
   localparam int SHW_N = $clog2(NARROW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic              lane_sel,
   input  logic [XLEN-1:0]   src_a,
   input  logic [XLEN-1:0]   src_b,
   input  logic [SHW_W-1:0]  shamt,
   output logic              out_valid,
   output logic [XLEN-1:0]   rd_data
);
   if (NARROW >= WIDE || WIDE % NARROW != 0 || XLEN % WIDE != 0) begin : g_bad_cfg
      $error("lane widths must nest: NARROW < WIDE, both dividing XLEN");
   end

   simd_op_e        op_e;
   logic [XLEN-1:0] res_wide, res_narrow, res_sel;

   assign op_e = simd_op_e'(op);

   simd_lane_array #(.XLEN(XLEN), .W(WIDE)) u_wide (
      .op    (op_e),
      .a     (src_a),
      .b     (src_b),
      .shamt (shamt),
      .y     (res_wide)
   );

   simd_lane_array #(.XLEN(XLEN), .W(NARROW)) u_narrow (
      .op    (op_e),
      .a     (src_a),
      .b     (src_b),
      .shamt (shamt[SHW_N-1:0]),
      .y     (res_narrow)
   );

   assign res_sel = lane_sel ? res_narrow : res_wide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         rd_data   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) rd_data <= res_sel;
      end
   end

   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(rd_data));
endmodule

// File: tb/tb_simd_sat_alu.sv
module tb_simd_sat_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic        lane_sel = 1'b0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [3:0]  shamt = '0;
   logic        out_valid;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] last_exp = '0;
   bit          done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   simd_sat_alu dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
      .src_a(src_a), .src_b(src_b), .shamt(shamt),
      .out_valid(out_valid), .rd_data(rd_data)
   );

   function automatic logic [31:0] ref_model(int code, bit n8, logic [31:0] a,
                                             logic [31:0] b, int sh);
      int w = n8 ? 8 : 16;
      longint mask = (64'd1 << w) - 1;
      longint half = 64'd1 << (w - 1);
      logic [31:0] res = '0;
      for (int k = 0; k < 32 / w; k++) begin
         longint ua = (longint'(a) >> (k * w)) & mask;
         longint ub = (longint'(b) >> (k * w)) & mask;
         longint sa = (ua >= half) ? ua - 2 * half : ua;
         longint sb = (ub >= half) ? ub - 2 * half : ub;
         int     s  = sh % w;
         longint r;
         case (code)
            0: r = ua + ub;
            1: r = ua - ub;
            2: begin r = sa + sb; if (r > half - 1) r = half - 1; if (r < -half) r = -half; end
            3: begin r = ua + ub; if (r > mask) r = mask; end
            4: begin r = sa - sb; if (r > half - 1) r = half - 1; if (r < -half) r = -half; end
            5: begin r = ua - ub; if (r < 0) r = 0; end
            6: r = (sa < sb) ? ua : ub;
            7: r = (ua < ub) ? ua : ub;
            8: r = (sa > sb) ? ua : ub;
            9: r = (ua > ub) ? ua : ub;
            10: r = ua << s;
            11: r = ua >> s;
            12: r = sa >>> s;
            default: r = 0;
         endcase
         r = r & mask;
         res = res | 32'(r << (k * w));
      end
      return res;
   endfunction

   task automatic send(int code, bit n8, logic [31:0] a, logic [31:0] b, int sh, string tag);
      logic [31:0] e;
      @(negedge clk);
      op = 4'(code); lane_sel = n8; src_a = a; src_b = b; shamt = 4'(sh); in_valid = 1'b1;
      e = ref_model(code, n8, a, b, sh);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      last_exp = e;
   endtask

   // Scoreboard monitor: pop and compare each produced result.
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected result: actual %h expected none", rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   initial begin
      #(20 * 5000);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rd_data !== 32'h0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual %h/%b expected 00000000/0", rd_data, out_valid);
      end
      rst_n = 1'b1;

      // R3 wrap, no carry across lanes; R2 lane select
      send(0, 0, 32'h00FF_00FF, 32'h0001_0001, 0, "R2 R3 add16");
      send(0, 1, 32'h00FF_00FF, 32'h0001_0001, 0, "R2 R3 add8");
      send(0, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R3 add16 wrap");
      send(1, 1, 32'h0000_0000, 32'h0101_0101, 0, "R3 sub8 borrow");
      send(1, 0, 32'h0001_0000, 32'h0000_0001, 0, "R3 sub16 no borrow");
      // R4 signed saturation
      send(2, 1, 32'h7F80_7F01, 32'h01FF_7F01, 0, "R4 sadd8");
      send(2, 0, 32'h7FFF_8000, 32'h0001_FFFF, 0, "R4 sadd16");
      send(4, 1, 32'h807F_0010, 32'h01FF_0020, 0, "R4 ssub8");
      send(4, 0, 32'h8000_7FFF, 32'h0001_FFFF, 0, "R4 ssub16");
      // R5 unsigned saturation
      send(3, 1, 32'hFF00_80FE, 32'h0100_8001, 0, "R5 uadd8");
      send(3, 0, 32'hFFFF_1234, 32'h0001_0001, 0, "R5 uadd16");
      send(5, 1, 32'h0010_FF05, 32'h0101_FF06, 0, "R5 usub8");
      send(5, 0, 32'h0000_8000, 32'h0001_7FFF, 0, "R5 usub16");
      // R6 / R7 min and max
      send(6, 1, 32'h807F_00FF, 32'h7F80_FF01, 0, "R6 mins8");
      send(7, 1, 32'h807F_00FF, 32'h7F80_FF01, 0, "R6 minu8");
      send(6, 0, 32'h8000_0005, 32'h7FFF_0003, 0, "R6 mins16");
      send(8, 1, 32'h807F_00FF, 32'h7F80_FF01, 0, "R7 maxs8");
      send(9, 0, 32'h8000_0005, 32'h7FFF_0003, 0, "R7 maxu16");
      send(8, 0, 32'h8000_FFFF, 32'h7FFF_0000, 0, "R7 maxs16");
      // R8 / R9 shifts
      send(10, 1, 32'h81FF_0F01, 32'h0, 1, "R8 sll8");
      send(10, 1, 32'h81FF_0F01, 32'h0, 9, "R8 sll8 mod");
      send(10, 0, 32'h8001_00FF, 32'h0, 15, "R8 sll16");
      send(11, 1, 32'h80FF_0F01, 32'h0, 3, "R9 srl8");
      send(12, 1, 32'h80FF_7F01, 32'h0, 3, "R9 sra8");
      send(12, 1, 32'h80FF_7F01, 32'h0, 15, "R9 sra8 mod");
      send(12, 0, 32'h8000_7FFF, 32'h0, 4, "R9 sra16");
      send(11, 0, 32'h8000_7FFF, 32'h0, 4, "R9 srl16");
      // R10 unused codes
      send(13, 0, 32'hDEAD_BEEF, 32'h1234_5678, 3, "R10 code13");
      send(15, 1, 32'hDEAD_BEEF, 32'h1234_5678, 3, "R10 code15");
      send(9, 1, 32'hA5A5_5A5A, 32'h5A5A_A5A5, 0, "R7 maxu8");

      // R11 hold while idle with changing inputs
      @(negedge clk);
      in_valid = 1'b0; op = 4'd0; src_a = 32'hFFFF_FFFF; src_b = 32'h1111_1111;
      @(negedge clk);
      src_a = 32'h0; lane_sel = ~lane_sel;
      @(negedge clk);
      checks++;
      if (rd_data !== last_exp || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11 hold: actual %h/%b expected %h/0", rd_data, out_valid, last_exp);
      end
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule